// File: doc/BRIEF.md
# First-Come DMA Channel Arbiter

This block decides which of eleven DMA channels may use a single shared transfer engine. Each channel drives a request level and carries two configuration bits from its own setup: an enable and a 2D-memory-mode flag. The arbiter keeps pending channels in arrival order and hands the engine to the oldest one. The engine answers with a one-cycle done pulse when it finishes the granted channel's work. Fixed priority matters only when several requests appear in the same clock cycle, and the highest-numbered channel then goes first.

The arbiter also watches the channel setups for an illegal combination: two or more enabled channels in 2D memory mode at once. When that happens it raises a configuration error that stays set until reset. While the conflict lasts, it will not hand the engine to a channel in 2D mode.

Top module: `dma_fcfs_arb`

## Requirements
- R1: After reset, `grant` is all zeros and `cfg_err` is 0.
- R2: A channel is taken into the pending list on a clock edge where its `req` bit and its `ch_en` bit are both 1 and the channel is neither pending nor granted. A channel with `ch_en` low is never granted, even while its `req` bit is high.
- R3: `grant` has at most one bit set, and bit c stands for channel c.
- R4: A grant stays unchanged until a clock edge at which `done` is 1. On that edge the grant moves to the next eligible pending channel, or clears to zero if there is none.
- R5: Channels whose requests arrive in different cycles are granted in the order of arrival, whatever their channel numbers.
- R6: Requests that arrive in the same cycle are ordered by descending channel number, so channel 10 is served first and channel 0 last.
- R7: A channel whose request stays high through its own grant is not pending a second time during that grant. It re-enters the list only after its done edge, behind any channel that was already pending.
- R8: Clearing a pending channel's `ch_en` bit removes that channel from the pending list. The relative order of the other entries is kept.
- R9: `cfg_err` becomes 1 one cycle after an edge at which more than one channel has both `ch_en` and `mode_2d` set. It then stays 1 until reset.
- R10: While more than one enabled channel is in 2D mode, a pending channel in 2D mode at the head of the list is not granted. It keeps its place and holds back the entries behind it until the conflict clears.
- R11: A single enabled channel in 2D mode is granted normally and does not set `cfg_err`.
- R12: When the arbiter is idle, a request raised before edge k is pending after edge k and granted on edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_CH | Per-channel request levels |
| ch_en | input | NUM_CH | Per-channel enable |
| mode_2d | input | NUM_CH | Per-channel 2D-memory-mode flag |
| done | input | 1 | Engine finished the granted channel (one-cycle pulse) |
| grant | output | NUM_CH | One-hot grant to the channel being served |
| cfg_err | output | 1 | Sticky flag: more than one enabled channel in 2D mode |

## Verification
The bench builds the arbiter with its default of eleven channels, so the extreme tie case (channel 10 against channel 0) and a pending list near its full depth can both be reached. The engine is modelled with a hold of three cycles per grant. That hold is long enough for later requests to arrive while a grant is active, which lets arrival order be told apart from channel priority, and it allows an enable to drop while the channel is waiting in the list. The 2D conflict is built from two real channel setups, so both the head-of-line stall and the sticky error can be observed at the ports.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Population count over a word of up to 32 channel flags.
  function automatic logic [5:0] pop_count32(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {5'd0, v[i]};
    return n;
  endfunction

  // True when more than one flag in the word is set.
  function automatic logic several_set(input logic [31:0] v);
    return pop_count32(v) > 6'd1;
  endfunction

endpackage

// File: rtl/dma_arb_order.sv
module dma_arb_order #(
  parameter int NUM_CH = 11,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] arrive,
  input  logic [NUM_CH-1:0] keep,
  input  logic              pop,
  output logic [IDX_W-1:0]  head_idx,
  output logic              head_valid,
  output logic [NUM_CH-1:0] queued,
  output logic [CNT_W-1:0]  depth
);

  logic [IDX_W-1:0] slot  [NUM_CH];
  logic [IDX_W-1:0] nslot [NUM_CH];
  logic [CNT_W-1:0] cnt, ncnt;

  // Keep surviving entries in order, then append new arrivals highest channel first.
  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < NUM_CH; i++) nslot[i] = slot[i];
    for (int i = 0; i < NUM_CH; i++) begin
      if ((CNT_W'(i) < cnt) && !(pop && i == 0) && keep[slot[i]]) begin
        nslot[k] = slot[i];
        k = k + 1;
      end
    end
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (arrive[c]) begin
        nslot[k] = IDX_W'(c);
        k = k + 1;
      end
    end
    ncnt = CNT_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < NUM_CH; i++) slot[i] <= '0;
    end else begin
      cnt <= ncnt;
      for (int i = 0; i < NUM_CH; i++) slot[i] <= nslot[i];
    end
  end

  always_comb begin
    queued = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (CNT_W'(i) < cnt) queued[slot[i]] = 1'b1;
  end

  assign head_idx   = slot[0];
  assign head_valid = (cnt != '0);
  assign depth      = cnt;

endmodule

// File: rtl/dma_arb_cfgchk.sv
module dma_arb_cfgchk #(
  parameter int NUM_CH = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] mode_2d,
  output logic              multi2d,
  output logic              cfg_err
);
  import dma_arb_pkg::*;

  assign multi2d = several_set(32'(ch_en & mode_2d));

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_err <= 1'b0;
    else if (multi2d) cfg_err <= 1'b1;
  end

endmodule

// File: rtl/dma_fcfs_arb.sv
module dma_fcfs_arb #(
  parameter int NUM_CH = 11,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] mode_2d,
  input  logic              done,
  output logic [NUM_CH-1:0] grant,
  output logic              cfg_err
);

  logic [NUM_CH-1:0] arrive;
  logic [NUM_CH-1:0] queued;
  logic [IDX_W-1:0]  head_idx;
  logic              head_valid;
  logic [CNT_W-1:0]  depth;
  logic              multi2d;
  logic              head_ok;
  logic              slot_free;
  logic              load;

  // New arrivals: requesting, enabled, not already waiting or being served.
  assign arrive = req & ch_en & ~queued & ~grant;

  assign head_ok   = head_valid && ch_en[head_idx] && !(mode_2d[head_idx] && multi2d);
  assign slot_free = (grant == '0) || done;
  assign load      = slot_free && head_ok;

  dma_arb_order #(.NUM_CH(NUM_CH)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive    (arrive),
    .keep      (ch_en),
    .pop       (load),
    .head_idx  (head_idx),
    .head_valid(head_valid),
    .queued    (queued),
    .depth     (depth)
  );

  dma_arb_cfgchk #(.NUM_CH(NUM_CH)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ch_en  (ch_en),
    .mode_2d(mode_2d),
    .multi2d(multi2d),
    .cfg_err(cfg_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    grant <= '0;
    else if (load) grant <= {{(NUM_CH-1){1'b0}}, 1'b1} << head_idx;
    else if (done) grant <= '0;
  end

endmodule

// File: rtl/dma_fcfs_arb_chk.sv
module dma_fcfs_arb_chk #(
  parameter int NUM_CH = 11,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] mode_2d,
  input logic              done,
  input logic [NUM_CH-1:0] grant,
  input logic              cfg_err,
  input logic [NUM_CH-1:0] queued,
  input logic [CNT_W-1:0]  depth,
  input logic              multi2d
);

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r4_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !done) |=> grant == $past(grant));

  a_r4_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && done) |=> grant != $past(grant));

  a_r7_no_double_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (queued & grant) == '0);

  a_r8_list_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(NUM_CH));

  a_r2_grant_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && grant != $past(grant)) |-> (grant & $past(ch_en)) != '0);

  a_r9_error_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ch_en & mode_2d) > 1) |=> cfg_err);

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r10_no_2d_in_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && grant != $past(grant)) |->
      !($past(multi2d) && (grant & $past(mode_2d)) != '0));

endmodule

bind dma_fcfs_arb dma_fcfs_arb_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ch_en  (ch_en),
  .mode_2d(mode_2d),
  .done   (done),
  .grant  (grant),
  .cfg_err(cfg_err),
  .queued (queued),
  .depth  (depth),
  .multi2d(multi2d)
);

// File: tb/dma_fcfs_arb_bench.sv
module dma_fcfs_arb_bench;
  localparam int CLK_P = 10;
  localparam int NCH   = 11;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] req, ch_en, mode_2d;
  logic           done;
  logic [NCH-1:0] grant;
  logic           cfg_err;

  int checks = 0;
  int errors = 0;
  int expq[$];
  string tagq[$];
  int regrant_left[NCH];
  logic [NCH-1:0] prev_grant;
  logic prev_done;
  int hold;
  int hold_len = 3;

  always #(CLK_P/2) clk = ~clk;

  dma_fcfs_arb u_dma_fcfs_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .ch_en(ch_en), .mode_2d(mode_2d),
    .done(done), .grant(grant), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] bit_of(input int c);
    return {{(NCH-1){1'b0}}, 1'b1} << c;
  endfunction

  task automatic expect_grant(input int c, input string tag);
    expq.push_back(c);
    tagq.push_back(tag);
  endtask

  // One cycle: scoreboard monitor plus a simple engine model that issues done.
  task automatic step();
    int ch;
    string tag;
    @(negedge clk);
    if (prev_grant != '0 && !prev_done)
      check(grant == prev_grant, "R4 hold", 32'(grant), 32'(prev_grant));
    if (prev_grant != '0 && prev_done)
      check(grant != prev_grant, "R4 release", 32'(grant), 32'(prev_grant));
    if (grant != '0 && (grant != prev_grant || prev_done)) begin
      if (expq.size() == 0) begin
        check(1'b0, "unexpected grant", 32'(grant), 32'(0));
      end else begin
        ch  = expq.pop_front();
        tag = tagq.pop_front();
        check(grant == bit_of(ch), tag, 32'(grant), 32'(bit_of(ch)));
      end
      for (int c = 0; c < NCH; c++) begin
        if (grant[c]) begin
          if (regrant_left[c] > 0) regrant_left[c]--;
          else req[c] = 1'b0;
        end
      end
      hold = 0;
    end
    if (grant != '0) begin
      hold++;
      done = (hold >= hold_len);
    end else begin
      done = 1'b0;
    end
    prev_grant = grant;
    prev_done  = done;
  endtask

  task automatic drain(input string tag);
    for (int n = 0; n < 300; n++) begin
      if (expq.size() == 0 && grant == '0 && !prev_done) break;
      step();
    end
    check(expq.size() == 0, tag, 32'(expq.size()), 32'(0));
  endtask

  task automatic expect_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step();
      check(grant == '0, tag, 32'(grant), 32'(0));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0; ch_en = '1; mode_2d = '0; done = 1'b0;
    prev_grant = '0; prev_done = 1'b0; hold = 0;
    for (int c = 0; c < NCH; c++) regrant_left[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    step();
    check(grant == '0, "R1 grant after reset", 32'(grant), 32'(0));
    check(cfg_err == 1'b0, "R1 cfg_err after reset", 32'(cfg_err), 32'(0));

    // R12 latency and R2 intake from idle
    req[5] = 1'b1;
    expect_grant(5, "R12 R2 single request");
    step();
    check(grant == '0, "R12 not yet granted", 32'(grant), 32'(0));
    step();
    check(grant == bit_of(5), "R12 granted on second edge", 32'(grant), 32'(bit_of(5)));
    drain("R12 drained");

    // R6 same-cycle arrivals: highest channel first
    req[0] = 1'b1; req[3] = 1'b1; req[7] = 1'b1; req[10] = 1'b1;
    expect_grant(10, "R6 tie first");
    expect_grant(7,  "R6 tie second");
    expect_grant(3,  "R6 tie third");
    expect_grant(0,  "R6 tie last");
    drain("R6 drained");

    // R5 arrival order beats channel number
    req[1] = 1'b1; expect_grant(1, "R5 first arrival");
    step();
    req[5] = 1'b1; expect_grant(5, "R5 second arrival");
    step();
    req[8] = 1'b1; expect_grant(8, "R5 third arrival");
    drain("R5 drained");

    // R8 removal by enable; R2 disabled channel never granted
    req[2] = 1'b1; req[4] = 1'b1; req[6] = 1'b1;
    expect_grant(6, "R8 head before removal");
    expect_grant(2, "R8 order kept after removal");
    step();
    step();
    ch_en[4] = 1'b0;
    drain("R8 drained");
    expect_idle(4, "R2 disabled channel not granted");
    req[4] = 1'b0; ch_en[4] = 1'b1;

    // R7 held request re-enters behind an earlier waiter
    regrant_left[3] = 1;
    req[3] = 1'b1; expect_grant(3, "R7 first grant");
    step();
    step();
    req[6] = 1'b1; expect_grant(6, "R7 waiter served before re-entry");
    expect_grant(3, "R7 re-entry after done");
    drain("R7 drained");

    // R11 lone 2D channel
    mode_2d[4] = 1'b1;
    req[4] = 1'b1; expect_grant(4, "R11 lone 2D granted");
    drain("R11 drained");
    check(cfg_err == 1'b0, "R11 no error", 32'(cfg_err), 32'(0));

    // R9 / R10 conflict with head-of-line stall
    req[5] = 1'b1; expect_grant(5, "R10 non-2D before conflict");
    step();
    step();
    mode_2d[9] = 1'b1;
    req[9] = 1'b1;
    step();
    step();
    check(cfg_err == 1'b1, "R9 error raised", 32'(cfg_err), 32'(1));
    req[7] = 1'b1;
    drain("R10 first drained");
    expect_idle(5, "R10 2D head blocks list");
    mode_2d[4] = 1'b0;
    expect_grant(9, "R10 2D head after conflict clears");
    expect_grant(7, "R10 follower after head");
    drain("R10 drained");
    check(cfg_err == 1'b1, "R9 error sticky", 32'(cfg_err), 32'(1));

    // R1 reset clears the error
    do_reset();
    step();
    check(cfg_err == 1'b0, "R1 error cleared by reset", 32'(cfg_err), 32'(0));
    check(grant == '0, "R1 grant cleared by reset", 32'(grant), 32'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule